// File: doc/BRIEF.md
# Pixel-Count Display Timing Generator

This block produces horizontal sync, vertical sync, data-enable and the outgoing pixel word for a parallel LCD panel, all from a single pixel clock. Horizontal timing is defined by a line length and a sync width. Vertical timing is not defined in lines. It is defined as absolute pixel-clock positions within a frame: the frame length, the vsync length and the vertical active window are all counted in pixel clocks from the vsync leading edge. A skew term is added to the vertical window, so the window can open or close part-way through a line.

Software places a complete timing set on the configuration inputs. The block copies that set into its working registers only while it is idle or on the last clock of a frame, so a set that is rewritten in the middle of a frame never tears that frame. Dropping the enable also waits for the frame boundary, so the frame in progress always completes. Within the active window the pixel stream is passed through. When the upstream fetch reports an underflow, a programmable fill colour can be substituted. Outside the window a border colour is driven.

Top module: `lcd_tgen`

## Requirements
- R1: While reset is asserted, hsync, vsync, de and pix_out are all 0.
- R2: While idle, de is 0, both syncs sit at their inactive level and pix_out carries the border colour. An enable sampled high at a clock edge while idle starts a frame. Frame position 0 appears on the outputs one edge later, and every output lags its frame position by one clock.
- R3: The hsync active level covers the first cfg_hs_width clocks of every line of cfg_line_len clocks. The line position restarts at 0 at every frame start.
- R4: The vsync active level covers frame positions 0 to cfg_vs_len−1. A frame lasts cfg_frame_len clocks and then restarts at position 0.
- R5: de is 1 exactly when two conditions hold: the line position lies in [cfg_hact_first, cfg_hact_last], and the frame position lies in [cfg_vact_first+cfg_vskew, cfg_vact_last+cfg_vskew]. Both ranges include their end points.
- R6: cfg_hs_neg=1 makes hsync active-low, and cfg_vs_neg=1 makes vsync active-low. Each bit inverts only its own sync, and the inversion also applies while idle.
- R7: While de is 1, pix_valid=1 outputs pix_in. pix_valid=0 with cfg_recover=1 outputs cfg_fill.
- R8: While de is 1, pix_valid=0 with cfg_recover=0 outputs pix_in unchanged. While de is 0, pix_out carries cfg_border.
- R9: en=0 stops the generator only after the last clock of the current frame. If en is 1 again by that edge, the next frame follows without a gap.
- R10: Configuration inputs are taken only while idle or on the last clock of a frame. Changes made mid-frame first affect the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run request, acted on at frame boundary or while idle |
| cfg_hs_width | input | HW | hsync pulse width in clocks |
| cfg_line_len | input | HW | Line length in clocks |
| cfg_hact_first | input | HW | First active line position |
| cfg_hact_last | input | HW | Last active line position |
| cfg_vskew | input | HW | Skew added to both vertical window bounds |
| cfg_frame_len | input | FW | Frame length in clocks |
| cfg_vs_len | input | FW | vsync length in clocks |
| cfg_vact_first | input | FW | First active frame position before skew |
| cfg_vact_last | input | FW | Last active frame position before skew |
| cfg_border | input | PW | Colour outside the active window |
| cfg_fill | input | PW | Colour substituted on underflow |
| cfg_recover | input | 1 | Enables fill substitution on underflow |
| cfg_hs_neg | input | 1 | hsync active-low when 1 |
| cfg_vs_neg | input | 1 | vsync active-low when 1 |
| pix_in | input | PW | Incoming pixel word |
| pix_valid | input | 1 | 1 = pixel valid, 0 = underflow |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_out | output | PW | Outgoing pixel word |

## Verification
Stopping the generator and reloading the timing set share one instant, the last clock of a frame. The bench provokes this by dropping en and writing a different line and frame length on exactly that clock. It judges the result by checking that the outputs go idle at once, and that the next enabled frame runs entirely on the new lengths. A second collision is a mid-frame write of polarity, recover and window settings while underflows occur inside the window. Every output is compared cycle by cycle against an arithmetic model, which must show the old settings holding until the boundary.

// File: rtl/lcd_tgen_pkg.sv
package lcd_tgen_pkg;

   typedef enum logic [1:0] {
      SRC_BORDER = 2'd0,
      SRC_PIXEL  = 2'd1,
      SRC_FILL   = 2'd2
   } pix_src_e;

   function automatic logic drive_level(input logic active, input logic low_true);
      return active ^ low_true;
   endfunction

endpackage

// File: rtl/lcd_tgen_seq.sv
module lcd_tgen_seq #(
   parameter int HW = 12,
   parameter int FW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [HW-1:0] act_line_len,
   input  logic [FW-1:0] act_frame_len,
   output logic          run,
   output logic [HW-1:0] hcnt,
   output logic [FW-1:0] fcnt,
   output logic          load
);

   logic frame_last;
   logic line_last;

   assign frame_last = run && (fcnt == act_frame_len - FW'(1));
   assign line_last  = (hcnt == act_line_len - HW'(1));
   assign load       = !run || frame_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run  <= 1'b0;
         hcnt <= '0;
         fcnt <= '0;
      end else if (!run || frame_last) begin
         hcnt <= '0;
         fcnt <= '0;
         run  <= en;
      end else begin
         fcnt <= fcnt + FW'(1);
         hcnt <= line_last ? '0 : hcnt + HW'(1);
      end
   end

endmodule

// File: rtl/lcd_tgen_shadow.sv
module lcd_tgen_shadow #(
   parameter int HW = 12,
   parameter int FW = 24,
   parameter int PW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [HW-1:0] cfg_hs_width,
   input  logic [HW-1:0] cfg_line_len,
   input  logic [HW-1:0] cfg_hact_first,
   input  logic [HW-1:0] cfg_hact_last,
   input  logic [HW-1:0] cfg_vskew,
   input  logic [FW-1:0] cfg_frame_len,
   input  logic [FW-1:0] cfg_vs_len,
   input  logic [FW-1:0] cfg_vact_first,
   input  logic [FW-1:0] cfg_vact_last,
   input  logic [PW-1:0] cfg_border,
   input  logic [PW-1:0] cfg_fill,
   input  logic          cfg_recover,
   input  logic          cfg_hs_neg,
   input  logic          cfg_vs_neg,
   output logic [HW-1:0] act_hs_width,
   output logic [HW-1:0] act_line_len,
   output logic [HW-1:0] act_hact_first,
   output logic [HW-1:0] act_hact_last,
   output logic [HW-1:0] act_vskew,
   output logic [FW-1:0] act_frame_len,
   output logic [FW-1:0] act_vs_len,
   output logic [FW-1:0] act_vact_first,
   output logic [FW-1:0] act_vact_last,
   output logic [PW-1:0] act_border,
   output logic [PW-1:0] act_fill,
   output logic          act_recover,
   output logic          act_hs_neg,
   output logic          act_vs_neg
);

   localparam int CW = 5*HW + 4*FW + 2*PW + 3;
   localparam int ZW = 5*HW + 4*FW + PW;
   // fill colour resets to all ones, every other field to zero
   localparam logic [CW-1:0] RST_VAL = {{ZW{1'b0}}, {PW{1'b1}}, 3'b000};

   logic [CW-1:0] cfg_bus;
   logic [CW-1:0] act_bus;

   assign cfg_bus = {cfg_hs_width, cfg_line_len, cfg_hact_first, cfg_hact_last, cfg_vskew,
                     cfg_frame_len, cfg_vs_len, cfg_vact_first, cfg_vact_last,
                     cfg_border, cfg_fill, cfg_recover, cfg_hs_neg, cfg_vs_neg};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    act_bus <= RST_VAL;
      else if (load) act_bus <= cfg_bus;
   end

   assign {act_hs_width, act_line_len, act_hact_first, act_hact_last, act_vskew,
           act_frame_len, act_vs_len, act_vact_first, act_vact_last,
           act_border, act_fill, act_recover, act_hs_neg, act_vs_neg} = act_bus;

endmodule

// File: rtl/lcd_tgen_decode.sv
module lcd_tgen_decode
   import lcd_tgen_pkg::*;
#(
   parameter int HW      = 12,
   parameter int FW      = 24,
   parameter int PW      = 24,
   parameter bit OUT_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [HW-1:0] hcnt,
   input  logic [FW-1:0] fcnt,
   input  logic [HW-1:0] act_hs_width,
   input  logic [HW-1:0] act_hact_first,
   input  logic [HW-1:0] act_hact_last,
   input  logic [HW-1:0] act_vskew,
   input  logic [FW-1:0] act_vs_len,
   input  logic [FW-1:0] act_vact_first,
   input  logic [FW-1:0] act_vact_last,
   input  logic [PW-1:0] act_border,
   input  logic [PW-1:0] act_fill,
   input  logic          act_recover,
   input  logic          act_hs_neg,
   input  logic          act_vs_neg,
   input  logic [PW-1:0] pix_in,
   input  logic          pix_valid,
   output logic          hsync,
   output logic          vsync,
   output logic          de,
   output logic [PW-1:0] pix_out
);

   localparam int XW = FW + 1;

   logic [XW-1:0] vfirst;
   logic [XW-1:0] vlast;
   logic [XW-1:0] fpos;
   logic          hwin;
   logic          vwin;
   logic          hs_n;
   logic          vs_n;
   logic          de_n;
   logic [PW-1:0] pix_n;
   pix_src_e      src;

   assign fpos   = {1'b0, fcnt};
   assign vfirst = {1'b0, act_vact_first} + {{(XW-HW){1'b0}}, act_vskew};
   assign vlast  = {1'b0, act_vact_last}  + {{(XW-HW){1'b0}}, act_vskew};

   assign hwin = (hcnt >= act_hact_first) && (hcnt <= act_hact_last);
   assign vwin = (fpos >= vfirst) && (fpos <= vlast);
   assign de_n = run && hwin && vwin;
   assign hs_n = drive_level(run && (hcnt < act_hs_width), act_hs_neg);
   assign vs_n = drive_level(run && (fcnt < act_vs_len),   act_vs_neg);

   always_comb begin
      if (!de_n)            src = SRC_BORDER;
      else if (pix_valid)   src = SRC_PIXEL;
      else if (act_recover) src = SRC_FILL;
      else                  src = SRC_PIXEL;
   end

   always_comb begin
      case (src)
         SRC_PIXEL: pix_n = pix_in;
         SRC_FILL:  pix_n = act_fill;
         default:   pix_n = act_border;
      endcase
   end

   generate
      if (OUT_REG) begin : g_oreg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hsync   <= 1'b0;
               vsync   <= 1'b0;
               de      <= 1'b0;
               pix_out <= '0;
            end else begin
               hsync   <= hs_n;
               vsync   <= vs_n;
               de      <= de_n;
               pix_out <= pix_n;
            end
         end
      end else begin : g_ocomb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign hsync   = hs_n;
         assign vsync   = vs_n;
         assign de      = de_n;
         assign pix_out = pix_n;
      end
   endgenerate

endmodule

// File: rtl/lcd_tgen.sv
module lcd_tgen #(
   parameter int HW      = 12,
   parameter int FW      = 24,
   parameter int PW      = 24,
   parameter bit OUT_REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [HW-1:0] cfg_hs_width,
   input  logic [HW-1:0] cfg_line_len,
   input  logic [HW-1:0] cfg_hact_first,
   input  logic [HW-1:0] cfg_hact_last,
   input  logic [HW-1:0] cfg_vskew,
   input  logic [FW-1:0] cfg_frame_len,
   input  logic [FW-1:0] cfg_vs_len,
   input  logic [FW-1:0] cfg_vact_first,
   input  logic [FW-1:0] cfg_vact_last,
   input  logic [PW-1:0] cfg_border,
   input  logic [PW-1:0] cfg_fill,
   input  logic          cfg_recover,
   input  logic          cfg_hs_neg,
   input  logic          cfg_vs_neg,
   input  logic [PW-1:0] pix_in,
   input  logic          pix_valid,
   output logic          hsync,
   output logic          vsync,
   output logic          de,
   output logic [PW-1:0] pix_out
);

   generate
      if (HW < 2) begin : g_bad_hw
         $error("lcd_tgen: HW must be at least 2");
      end
      if (FW < HW) begin : g_bad_fw
         $error("lcd_tgen: FW must not be narrower than HW");
      end
      if (PW < 1) begin : g_bad_pw
         $error("lcd_tgen: PW must be at least 1");
      end
   endgenerate

   logic          run;
   logic          load;
   logic [HW-1:0] hcnt;
   logic [FW-1:0] fcnt;
   logic [HW-1:0] act_hs_width, act_line_len, act_hact_first, act_hact_last, act_vskew;
   logic [FW-1:0] act_frame_len, act_vs_len, act_vact_first, act_vact_last;
   logic [PW-1:0] act_border, act_fill;
   logic          act_recover, act_hs_neg, act_vs_neg;

   lcd_tgen_seq #(.HW(HW), .FW(FW)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (en),
      .act_line_len (act_line_len),
      .act_frame_len(act_frame_len),
      .run          (run),
      .hcnt         (hcnt),
      .fcnt         (fcnt),
      .load         (load)
   );

   lcd_tgen_shadow #(.HW(HW), .FW(FW), .PW(PW)) u_shadow (
      .clk           (clk),
      .rst_n         (rst_n),
      .load          (load),
      .cfg_hs_width  (cfg_hs_width),
      .cfg_line_len  (cfg_line_len),
      .cfg_hact_first(cfg_hact_first),
      .cfg_hact_last (cfg_hact_last),
      .cfg_vskew     (cfg_vskew),
      .cfg_frame_len (cfg_frame_len),
      .cfg_vs_len    (cfg_vs_len),
      .cfg_vact_first(cfg_vact_first),
      .cfg_vact_last (cfg_vact_last),
      .cfg_border    (cfg_border),
      .cfg_fill      (cfg_fill),
      .cfg_recover   (cfg_recover),
      .cfg_hs_neg    (cfg_hs_neg),
      .cfg_vs_neg    (cfg_vs_neg),
      .act_hs_width  (act_hs_width),
      .act_line_len  (act_line_len),
      .act_hact_first(act_hact_first),
      .act_hact_last (act_hact_last),
      .act_vskew     (act_vskew),
      .act_frame_len (act_frame_len),
      .act_vs_len    (act_vs_len),
      .act_vact_first(act_vact_first),
      .act_vact_last (act_vact_last),
      .act_border    (act_border),
      .act_fill      (act_fill),
      .act_recover   (act_recover),
      .act_hs_neg    (act_hs_neg),
      .act_vs_neg    (act_vs_neg)
   );

   lcd_tgen_decode #(.HW(HW), .FW(FW), .PW(PW), .OUT_REG(OUT_REG)) u_decode (
      .clk           (clk),
      .rst_n         (rst_n),
      .run           (run),
      .hcnt          (hcnt),
      .fcnt          (fcnt),
      .act_hs_width  (act_hs_width),
      .act_hact_first(act_hact_first),
      .act_hact_last (act_hact_last),
      .act_vskew     (act_vskew),
      .act_vs_len    (act_vs_len),
      .act_vact_first(act_vact_first),
      .act_vact_last (act_vact_last),
      .act_border    (act_border),
      .act_fill      (act_fill),
      .act_recover   (act_recover),
      .act_hs_neg    (act_hs_neg),
      .act_vs_neg    (act_vs_neg),
      .pix_in        (pix_in),
      .pix_valid     (pix_valid),
      .hsync         (hsync),
      .vsync         (vsync),
      .de            (de),
      .pix_out       (pix_out)
   );

endmodule

// File: rtl/lcd_tgen_chk.sv
module lcd_tgen_chk #(
   parameter int HW = 12,
   parameter int FW = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic          run,
   input logic          de,
   input logic [HW-1:0] hcnt,
   input logic [FW-1:0] fcnt,
   input logic [HW-1:0] act_line_len,
   input logic [FW-1:0] act_frame_len
);

   logic at_end;
   assign at_end = (fcnt == act_frame_len - FW'(1));

   // R2: no data enable follows an idle cycle
   p_idle_no_de_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(run) |-> !de);

   // R9: running only stops after the last frame clock
   p_run_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !at_end) |=> run);

   // R3: line position stays inside the line
   p_line_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (hcnt < act_line_len));

   // R4: frame position stays inside the frame
   p_frame_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (fcnt < act_frame_len));

   // R4: both positions restart after the last frame clock
   p_frame_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && at_end) |=> (fcnt == '0) && (hcnt == '0));

   // R10: active timing frozen inside a frame
   p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !at_end) |=> ($stable(act_line_len) && $stable(act_frame_len)));

endmodule

bind lcd_tgen lcd_tgen_chk #(.HW(HW), .FW(FW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .run          (run),
   .de           (de),
   .hcnt         (hcnt),
   .fcnt         (fcnt),
   .act_line_len (act_line_len),
   .act_frame_len(act_frame_len)
);

// File: tb/lcd_tgen_bench.sv
module lcd_tgen_bench;

   localparam int HW = 6;
   localparam int FW = 10;
   localparam int PW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic [HW-1:0] cfg_hs_width = '0, cfg_line_len = '0, cfg_hact_first = '0, cfg_hact_last = '0, cfg_vskew = '0;
   logic [FW-1:0] cfg_frame_len = '0, cfg_vs_len = '0, cfg_vact_first = '0, cfg_vact_last = '0;
   logic [PW-1:0] cfg_border = '0, cfg_fill = '0;
   logic          cfg_recover = 1'b0, cfg_hs_neg = 1'b0, cfg_vs_neg = 1'b0;
   logic [PW-1:0] pix_in = '0;
   logic          pix_valid = 1'b1;
   logic          hsync, vsync, de;
   logic [PW-1:0] pix_out;

   always #5 clk = ~clk;

   lcd_tgen #(.HW(HW), .FW(FW), .PW(PW), .OUT_REG(1'b1)) u_lcd_tgen (
      .clk(clk), .rst_n(rst_n), .en(en),
      .cfg_hs_width(cfg_hs_width), .cfg_line_len(cfg_line_len),
      .cfg_hact_first(cfg_hact_first), .cfg_hact_last(cfg_hact_last), .cfg_vskew(cfg_vskew),
      .cfg_frame_len(cfg_frame_len), .cfg_vs_len(cfg_vs_len),
      .cfg_vact_first(cfg_vact_first), .cfg_vact_last(cfg_vact_last),
      .cfg_border(cfg_border), .cfg_fill(cfg_fill), .cfg_recover(cfg_recover),
      .cfg_hs_neg(cfg_hs_neg), .cfg_vs_neg(cfg_vs_neg),
      .pix_in(pix_in), .pix_valid(pix_valid),
      .hsync(hsync), .vsync(vsync), .de(de), .pix_out(pix_out)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   string ph = "R2";
   int cyc = 0;
   bit underflow_on = 1'b0;

   // arithmetic model state
   int m_run, m_pos;
   int a_hsw, a_line, a_hf, a_hl, a_skew, a_frame, a_vsl, a_vf, a_vl, a_border, a_fill;
   int a_rec, a_hneg, a_vneg;
   int e_hs, e_vs, e_de, e_pix;
   int frame_de_count;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s [%s] cyc %0d: actual %0d expected %0d", req, ph, cyc, act, exp);
      end
   endtask

   task automatic model_load();
      a_hsw = int'(cfg_hs_width);   a_line = int'(cfg_line_len);
      a_hf = int'(cfg_hact_first);  a_hl = int'(cfg_hact_last);
      a_skew = int'(cfg_vskew);     a_frame = int'(cfg_frame_len);
      a_vsl = int'(cfg_vs_len);     a_vf = int'(cfg_vact_first);
      a_vl = int'(cfg_vact_last);   a_border = int'(cfg_border);
      a_fill = int'(cfg_fill);      a_rec = int'(cfg_recover);
      a_hneg = int'(cfg_hs_neg);    a_vneg = int'(cfg_vs_neg);
   endtask

   // predict outputs of the coming edge, then advance the model
   task automatic model_edge();
      int h, hs, vs, d;
      h  = (m_run != 0) ? (m_pos % a_line) : 0;
      hs = (m_run != 0 && h < a_hsw) ? 1 : 0;
      vs = (m_run != 0 && m_pos < a_vsl) ? 1 : 0;
      d  = (m_run != 0 && h >= a_hf && h <= a_hl &&
            m_pos >= a_vf + a_skew && m_pos <= a_vl + a_skew) ? 1 : 0;
      e_hs = hs ^ a_hneg;
      e_vs = vs ^ a_vneg;
      e_de = d;
      if (d == 0)             e_pix = a_border;
      else if (pix_valid)     e_pix = int'(pix_in);
      else if (a_rec != 0)    e_pix = a_fill;
      else                    e_pix = int'(pix_in);
      if (m_run == 0 || m_pos == a_frame - 1) begin
         m_pos = 0;
         model_load();
         m_run = int'(en);
      end else begin
         m_pos++;
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         pix_in    = PW'((cyc * 37 + 5) & 8'hFF);
         pix_valid = underflow_on ? ((cyc % 7) != 3) : 1'b1;
         model_edge();
         @(negedge clk);
         cyc++;
         chk("R3/R6 hsync", int'(hsync), e_hs);
         chk("R4/R6 vsync", int'(vsync), e_vs);
         chk("R5 de", int'(de), e_de);
         chk("R7/R8 pix_out", int'(pix_out), e_pix);
         if (de) frame_de_count++;
      end
   endtask

   task automatic to_frame_last();
      while (!(m_run != 0 && m_pos == a_frame - 1)) step(1);
   endtask

   initial begin
      cfg_hs_width = 6'd2;   cfg_line_len = 6'd10;
      cfg_hact_first = 6'd3; cfg_hact_last = 6'd7; cfg_vskew = 6'd3;
      cfg_frame_len = 10'd60; cfg_vs_len = 10'd10;
      cfg_vact_first = 10'd20; cfg_vact_last = 10'd49;
      cfg_border = 8'h5A; cfg_fill = 8'hC3; cfg_recover = 1'b1;

      // R1: outputs held low during reset
      repeat (3) @(negedge clk);
      chk("R1 hsync reset", int'(hsync), 0);
      chk("R1 vsync reset", int'(vsync), 0);
      chk("R1 de reset", int'(de), 0);
      chk("R1 pix_out reset", int'(pix_out), 0);

      m_run = 0; m_pos = 0;
      a_hsw = 0; a_line = 0; a_hf = 0; a_hl = 0; a_skew = 0; a_frame = 0;
      a_vsl = 0; a_vf = 0; a_vl = 0; a_border = 0; a_fill = 255;
      a_rec = 0; a_hneg = 0; a_vneg = 0;
      rst_n = 1'b1;

      // R2: idle outputs, then start
      ph = "R2 idle";
      step(4);
      en = 1'b1;
      ph = "R2 start";
      step(2);
      ph = "R3 R4 R5 main";
      step(118);

      // R7 and R8 underflow, recover flipped mid-frame (R10)
      ph = "R7 underflow";
      underflow_on = 1'b1;
      step(30);
      cfg_recover = 1'b0;
      ph = "R10 R8 recover off";
      step(90);
      cfg_recover = 1'b1;

      // R6 polarity change mid-frame with window change (R10)
      ph = "R6 polarity";
      cfg_hs_neg = 1'b1; cfg_vs_neg = 1'b1;
      cfg_hs_width = 6'd3; cfg_hact_first = 6'd4; cfg_vskew = 6'd5;
      step(100);
      cfg_hs_neg = 1'b0;
      step(60);

      // R9 disable mid-frame: frame completes with all its de cycles
      ph = "R9 disable";
      to_frame_last();
      step(1);
      frame_de_count = 0;
      step(20);
      en = 1'b0;
      step(40);
      chk("R9 de count of finished frame", frame_de_count, 30 * 4 / 10 * 0 + ((a_hl - a_hf + 1) * ((a_vl - a_vf + 1) / a_line)));
      ph = "R9 idle";
      step(10);
      chk("R9 de low after stop", int'(de), 0);

      // R9 re-enable before boundary keeps running
      en = 1'b1;
      ph = "R9 resume";
      step(30);
      en = 1'b0;
      step(10);
      en = 1'b1;
      step(60);

      // collision: stop and new lengths on the last frame clock (R9, R10)
      ph = "R10 collision";
      to_frame_last();
      en = 1'b0;
      cfg_line_len = 6'd12; cfg_frame_len = 10'd72; cfg_vs_len = 10'd12;
      cfg_vact_first = 10'd24; cfg_vact_last = 10'd59;
      step(1);
      step(8);
      chk("R9 stopped at boundary de", int'(de), 0);
      en = 1'b1;
      ph = "R10 new lengths";
      step(150);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule